// File: doc/BRIEF.md
# Programmable Length Serial Shift Register

This block is a one-bit delay line whose depth can be chosen at run time to any value from 1 to 64 stages. The chain starts with a single stage that is always in the path. Six further sections follow it, holding 1, 2, 4, 8, 16 and 32 stages. Each section is either placed in the path or bypassed by its own bit of a length-select word. The serial input comes from one of two data pins. The second pin can carry the output back in, which turns the block into a recirculating store. True and inverted serial outputs are provided.

Shifting is driven by two pins that are sampled on the system clock: a shift clock and an active-low shift enable. A shift takes place when the shift clock rises while the enable is low. It also takes place when the enable falls while the shift clock is high, so the enable pin can serve as a falling-edge clock of its own. Registered copies of both pins turn each such event into a single-cycle strobe. An active-low reset clears every stage at once. Its release is synchronized to the system clock.

Top module: `prog_shift_reg`

## Requirements
- R1: The length L is 1 plus the sum of the asserted weights of `len_sel_i`, where bit i weighs 2^i. L therefore ranges from 1 (all bits 0) to 64 (all bits 1). After k shift strobes since reset with a constant length, `q_o` equals the serial input bit of strobe k-L+1, or 0 when k < L.
- R2: The serial input is `din_a_i` when `src_sel_i` is 1 and `din_b_i` when it is 0.
- R3: A strobe, and so one shift, occurs when a system clock edge samples `shift_clk_i` at 1 after it was sampled at 0 on the previous edge, with `shift_en_n_i` sampled at 0.
- R4: A strobe also occurs when a system clock edge samples `shift_en_n_i` at 0 after it was 1 on the previous edge, with `shift_clk_i` sampled at 1.
- R5: No other input pattern shifts the register. This covers a shift-clock rise while the enable is 1, an enable fall while the shift clock is 0, falling shift-clock edges, rising enable edges and steady levels. Without a strobe, `q_o` holds.
- R6: While `rst_n` is 0, every stage is cleared and `q_o` is 0 without waiting for a clock edge. After release, the levels present on the shift pins cause no strobe.
- R7: `q_n_o` is always the inverse of `q_o`.
- R8: `q_o` always shows the last stage in the path for the current `len_sel_i`, including just after that word changes. A bypassed section neither shifts nor loses its contents, so putting it back in the path restores the bits it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| shift_clk_i | input | 1 | Shift clock, sampled on clk |
| shift_en_n_i | input | 1 | Active-low shift enable, also usable as a falling-edge shift clock |
| src_sel_i | input | 1 | Serial source select: 1 picks din_a_i, 0 picks din_b_i |
| din_a_i | input | 1 | Serial data source A |
| din_b_i | input | 1 | Serial data source B, typically fed back from q_o |
| len_sel_i | input | NUM_SECT | Section include bits; bit i adds 2^i stages |
| q_o | output | 1 | Serial output from the last stage in the path |
| q_n_o | output | 1 | Inverse of q_o |

## Verification
The bench builds the block with its default of six sections and a two-stage reset synchronizer. Every length from 1 to 64 is therefore small enough to sweep completely. Each length gets random data, random source selection and both kinds of strobe, and a delay-queue model checks the output. The six-section build also makes the full chain small enough to fill with known bits. The bench then reads back what individual bypassed sections retain, and checks recirculation through the B input and a reset applied mid-stream.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic {
    SRC_B = 1'b0,
    SRC_A = 1'b1
  } src_e;

  // depth of bypassable section idx: binary weighted
  function automatic int sect_depth(input int idx);
    return 1 << idx;
  endfunction

endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/psr_strobe_det.sv
module psr_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_clk_i,
  input  logic shift_en_n_i,
  output logic stb_o
);

  logic clk_q, clk_d;
  logic en_q, en_d;
  logic rise_hit, fall_hit;

  always_comb begin
    clk_d = shift_clk_i;
    en_d  = shift_en_n_i;
  end

  // reset values chosen so that levels seen at release are not events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      clk_q <= clk_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    rise_hit = shift_clk_i & ~clk_q & ~shift_en_n_i;
    fall_hit = shift_clk_i & en_q & ~shift_en_n_i;
    stb_o    = rise_hit | fall_hit;
  end

endmodule

// File: rtl/psr_section.sv
module psr_section #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic incl,
  input  logic d,
  output logic q
);

  logic tail;
  logic adv;

  assign adv = stb & incl;

  generate
    if (DEPTH == 1) begin : g_one
      logic bit_q, bit_d;

      always_comb begin
        bit_d = adv ? d : bit_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else begin
          bit_q <= bit_d;
        end
      end

      assign tail = bit_q;
    end else begin : g_many
      logic [DEPTH-1:0] sh_q, sh_d;

      always_comb begin
        sh_d = adv ? {sh_q[DEPTH-2:0], d} : sh_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q <= sh_d;
        end
      end

      assign tail = sh_q[DEPTH-1];
    end
  endgenerate

  // bypassed section passes its input straight through and keeps its bits
  assign q = incl ? tail : d;

endmodule

// File: rtl/prog_shift_reg.sv
module prog_shift_reg #(
  parameter int NUM_SECT    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_clk_i,
  input  logic                shift_en_n_i,
  input  logic                src_sel_i,
  input  logic                din_a_i,
  input  logic                din_b_i,
  input  logic [NUM_SECT-1:0] len_sel_i,
  output logic                q_o,
  output logic                q_n_o
);

  import psr_pkg::*;

  logic            rst_sync_n;
  logic            shift_stb;
  logic            ser_in;
  src_e            src;
  logic [NUM_SECT:0] link;

  psr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psr_strobe_det u_strobe (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .shift_clk_i  (shift_clk_i),
    .shift_en_n_i (shift_en_n_i),
    .stb_o        (shift_stb)
  );

  assign src = src_e'(src_sel_i);

  always_comb begin
    case (src)
      SRC_A:   ser_in = din_a_i;
      default: ser_in = din_b_i;
    endcase
  end

  psr_section #(.DEPTH(1)) u_fixed (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .stb   (shift_stb),
    .incl  (1'b1),
    .d     (ser_in),
    .q     (link[0])
  );

  generate
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      psr_section #(.DEPTH(sect_depth(i))) u_sect (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .stb   (shift_stb),
        .incl  (len_sel_i[i]),
        .d     (link[i]),
        .q     (link[i+1])
      );
    end
  endgenerate

  assign q_o   = link[NUM_SECT];
  assign q_n_o = ~link[NUM_SECT];

endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int NUM_SECT = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rst_sync_n,
  input logic                shift_stb,
  input logic                shift_clk_i,
  input logic                shift_en_n_i,
  input logic                src_sel_i,
  input logic                din_a_i,
  input logic                din_b_i,
  input logic [NUM_SECT-1:0] len_sel_i,
  input logic                q_o
);

  // R6: output low whenever reset is held
  assert_rst_clears_R6: assert property (@(posedge clk) disable iff (rst_n)
    !q_o);

  // R5: no strobe means the output holds unless the length word moved
  assert_no_stb_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !shift_stb |=> ($stable(q_o) || !$stable(len_sel_i)));

  // R5: enable high never strobes
  assert_en_high_quiet_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift_en_n_i |-> !shift_stb);

  // R3: shift-clock rise with enable low strobes
  assert_rise_strobes_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $rose(shift_clk_i) && !shift_en_n_i) |-> shift_stb);

  // R4: enable fall with shift clock high strobes
  assert_fall_strobes_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $fell(shift_en_n_i) && shift_clk_i) |-> shift_stb);

  // R2: single-stage length shows the selected source one cycle after a strobe
  assert_len1_src_a_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_stb && len_sel_i == '0 && src_sel_i) |=>
      (q_o == $past(din_a_i) || !$stable(len_sel_i)));

  assert_len1_src_b_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_stb && len_sel_i == '0 && !src_sel_i) |=>
      (q_o == $past(din_b_i) || !$stable(len_sel_i)));

endmodule

bind prog_shift_reg psr_checker #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .shift_stb    (shift_stb),
  .shift_clk_i  (shift_clk_i),
  .shift_en_n_i (shift_en_n_i),
  .src_sel_i    (src_sel_i),
  .din_a_i      (din_a_i),
  .din_b_i      (din_b_i),
  .len_sel_i    (len_sel_i),
  .q_o          (q_o)
);

// File: tb/prog_shift_reg_tb.sv
module prog_shift_reg_tb;

  localparam int NS = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          shift_clk_i;
  logic          shift_en_n_i;
  logic          src_sel_i;
  logic          din_a_i;
  logic          din_b_i;
  logic [NS-1:0] len_sel_i;
  logic          q_o;
  logic          q_n_o;

  prog_shift_reg #(.NUM_SECT(NS)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_clk_i  (shift_clk_i),
    .shift_en_n_i (shift_en_n_i),
    .src_sel_i    (src_sel_i),
    .din_a_i      (din_a_i),
    .din_b_i      (din_b_i),
    .len_sel_i    (len_sel_i),
    .q_o          (q_o),
    .q_n_o        (q_n_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit hist[$];
  int cur_len = 1;
  bit keep[64];

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic model_q();
    int n = hist.size();
    if (n >= cur_len) return hist[n - cur_len];
    return 1'b0;
  endfunction

  task automatic drv(input logic c, input logic e);
    @(negedge clk);
    shift_clk_i  = c;
    shift_en_n_i = e;
  endtask

  // kind 0: shift-clock rise with enable low; kind 1: enable fall with clock high
  task automatic do_shift(input int kind, input logic a, input logic b, input logic sel);
    @(negedge clk);
    din_a_i   = a;
    din_b_i   = b;
    src_sel_i = sel;
    hist.push_back(sel ? a : b);
    if (kind == 0) begin
      shift_clk_i = 1'b0; shift_en_n_i = 1'b0;
      drv(1'b1, 1'b0);
      drv(1'b0, 1'b0);
      drv(1'b0, 1'b1);
    end else begin
      shift_clk_i = 1'b1; shift_en_n_i = 1'b1;
      drv(1'b1, 1'b0);
      drv(1'b0, 1'b0);
      drv(1'b0, 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    shift_clk_i = 1'b0;
    shift_en_n_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hist.delete();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    shift_clk_i = 1'b1;
    shift_en_n_i = 1'b0;
    src_sel_i = 1'b1;
    din_a_i = 1'b1;
    din_b_i = 1'b1;
    len_sel_i = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset state q", q_o, 1'b0);
    chk("R7 reset state q_n", q_n_o, 1'b1);

    // R6: shift pins held at strobe-like levels through release
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 no strobe from levels at release", q_o, 1'b0);
    drv(1'b0, 1'b0);
    drv(1'b0, 1'b1);
    @(negedge clk);
    chk("R5 clock fall and enable rise ignored", q_o, 1'b0);

    // R5: patterns that must not shift
    din_a_i = 1'b1;
    drv(1'b0, 1'b1);
    drv(1'b1, 1'b1);
    drv(1'b0, 1'b1);
    @(negedge clk);
    chk("R5 clock rise with enable high ignored", q_o, 1'b0);
    drv(1'b0, 1'b1);
    drv(1'b0, 1'b0);
    drv(1'b0, 1'b1);
    @(negedge clk);
    chk("R5 enable fall with clock low ignored", q_o, 1'b0);

    // R3 / R4: the two strobe forms, length 1
    cur_len = 1;
    hist.delete();
    do_shift(0, 1'b1, 1'b0, 1'b1);
    chk("R3 clock-rise shift", q_o, 1'b1);
    do_shift(1, 1'b0, 1'b1, 1'b1);
    chk("R4 enable-fall shift", q_o, 1'b0);
    do_shift(1, 1'b1, 1'b0, 1'b1);
    chk("R4 enable-fall shift again", q_o, 1'b1);

    // R2: source selection
    do_shift(0, 1'b0, 1'b1, 1'b0);
    chk("R2 select 0 takes B", q_o, 1'b1);
    do_shift(0, 1'b0, 1'b1, 1'b1);
    chk("R2 select 1 takes A", q_o, 1'b0);
    do_shift(1, 1'b1, 1'b0, 1'b0);
    chk("R2 select 0 takes B low", q_o, 1'b0);

    // R1: every length, random data and source, both strobe forms
    for (int L = 1; L <= 64; L++) begin
      do_reset();
      len_sel_i = NS'(L - 1);
      cur_len = L;
      for (int j = 0; j < L + 4; j++) begin
        logic a, b, s;
        a = 1'($urandom);
        b = 1'($urandom);
        s = 1'($urandom);
        do_shift(j % 2, a, b, s);
        chk("R1 length sweep", q_o, model_q());
        chk("R7 complement", q_n_o, ~model_q());
      end
    end

    // R8: fill full chain, then bypass and restore sections
    do_reset();
    len_sel_i = '1;
    cur_len = 64;
    for (int j = 0; j < 64; j++) begin
      keep[j] = 1'($urandom);
      do_shift(j % 2, keep[j], ~keep[j], 1'b1);
    end
    chk("R1 full chain output", q_o, keep[0]);
    len_sel_i = '0;
    @(negedge clk);
    chk("R8 length 1 shows fixed stage", q_o, keep[63]);
    len_sel_i = NS'(1);
    @(negedge clk);
    chk("R8 one-stage section retained", q_o, keep[62]);
    len_sel_i = '1;
    @(negedge clk);
    chk("R8 restored full chain", q_o, keep[0]);
    len_sel_i = '0;
    do_shift(0, ~keep[63], 1'b0, 1'b1);
    chk("R8 shift at length 1", q_o, ~keep[63]);
    len_sel_i = NS'(1);
    @(negedge clk);
    chk("R8 bypassed section did not shift", q_o, keep[62]);
    len_sel_i = '1;
    @(negedge clk);
    chk("R8 last section retained", q_o, keep[0]);

    // recirculation through B, then a reset mid-stream
    do_reset();
    len_sel_i = NS'(4);
    cur_len = 5;
    for (int j = 0; j < 5; j++) do_shift(0, 1'(j % 2 == 0 || j == 3), 1'b0, 1'b1);
    for (int j = 0; j < 15; j++) begin
      do_shift(j % 2, 1'b0, q_o, 1'b0);
      chk("R2 recirculation via B", q_o, model_q());
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6 asynchronous clear", q_o, 1'b0);
    chk("R7 complement in reset", q_n_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hist.delete();
    for (int j = 0; j < 9; j++) begin
      logic a;
      a = 1'($urandom);
      do_shift(j % 2, a, ~a, 1'b1);
      chk("R1 after mid-stream reset", q_o, model_q());
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule